// File: doc/BRIEF.md
# Fractal Offset Inversion Sequencer

This block drives the offset-path inversion control for a chain of switched-capacitor integrators inside an incremental converter. For each conversion it steps through a ±1 pattern built recursively: the pattern of one order is the pattern of the order below, followed by that same pattern with every sign flipped. Each element of the pattern is held for a programmable number of clock periods. The pattern repeats for as many periods as the conversion lasts, so the integrated offset cancels at each pattern boundary.

A one-cycle start strobe captures the pattern order, the hold length and the conversion length, and then begins a conversion. During the conversion the block gives an inversion level and a pair of phase-select bits. The phase-select bits swap whenever the inversion is active, so the signal itself keeps its polarity. After the final period, the block spends exactly one cycle asserting a clear pulse that resets the integrators, and then it goes idle. A start strobe that arrives while a conversion is still running restarts the conversion. A start strobe that arrives in the final period, or during the clear cycle, is held until the clear cycle has finished.

Top module: `fractal_inv_seq`

## Requirements
- R1: After reset, inv_o is 0, busy_o is 0, clear_o is 0 and phase_sel_o is 2'b01.
- R2: start_i is sampled high at a clock edge. At the next edge, busy_o is 1 and the conversion is in period 0, with inv_o equal to 0.
- R3: In conversion period p, with hold length H and order K, the element index is e = floor(p/H). inv_o is 1 exactly when element (e mod 2^K) of the order-K pattern is −1. The pattern of order 0 is (+1). The pattern of order k+1 is the order-k pattern followed by its sign-swapped copy. With order 3 and H = 64, this gives + − − + − + + −, and each element lasts 64 periods.
- R4: Order 1 gives a plain alternation (+, −), one element per hold block. Order 4 gives the 16-element pattern.
- R5: phase_sel_o is 2'b01 when inv_o is 0 and 2'b10 when inv_o is 1.
- R6: busy_o stays high for exactly L periods, where L is the captured conversion length. In the next cycle clear_o is 1 and busy_o is 0, for exactly one cycle. After that the block is idle unless a start is pending.
- R7: Changes to order_i, hold_i and len_i while start_i is low have no effect on a running conversion, neither on its pattern nor on its length.
- R8: start_i is high during a period that is not the last one. The conversion restarts at period 0 with the newly captured settings, and no clear pulse is issued.
- R9: start_i is high in the last period, or in the clear cycle. The clear cycle still occurs, and the new conversion's period 0 follows it directly.
- R10: Settings out of range are limited when they are captured: order 0 behaves as 1, an order above 4 behaves as 4, a hold of 0 behaves as 1, and a length of 0 behaves as 1.
- R11: inv_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe; captures the settings |
| order_i | input | 3 | Pattern order, 1 to 4 |
| hold_i | input | 8 | Clock periods per pattern element |
| len_i | input | 12 | Clock periods per conversion |
| inv_o | output | 1 | Offset-path inversion level (1 = element −1) |
| phase_sel_o | output | 2 | Input-switch phase routing, swapped while inverting |
| busy_o | output | 1 | Conversion in progress |
| clear_o | output | 1 | One-cycle integrator clear after the final period |

## Verification
The two functions that can collide are the end of a conversion, which issues the clear pulse, and a new start strobe. The bench raises start_i in the last period of a short conversion, and also in the clear cycle. In both cases it expects a single cycle with clear_o high and busy_o low, followed directly by period 0 of the new conversion, with inv_o low and the newly captured settings. A start in a period that is not the last one is checked separately: it must restart the conversion without any clear pulse.

// File: rtl/fractal_inv_seq.sv
module fractal_inv_seq #(
  parameter int ORD_MAX = 4,
  parameter int HOLD_W  = 8,
  parameter int LEN_W   = 12,
  localparam int OW     = $clog2(ORD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OW-1:0]     order_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              inv_o,
  output logic [1:0]        phase_sel_o,
  output logic              busy_o,
  output logic              clear_o
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CLR} st_t;

  st_t               st;
  logic [OW-1:0]     ord_q, ord_n;
  logic [HOLD_W-1:0] hold_q, hold_n, hold_cnt;
  logic [LEN_W-1:0]  len_q, len_n, conv_cnt;
  logic [ORD_MAX-1:0] elem, msk;
  logic              pend, last, hold_end;

  assign ord_n  = (order_i == '0) ? OW'(1) :
                  (order_i > OW'(ORD_MAX)) ? OW'(ORD_MAX) : order_i;
  assign hold_n = (hold_i == '0) ? HOLD_W'(1) : hold_i;
  assign len_n  = (len_i == '0) ? LEN_W'(1) : len_i;

  assign last     = (st == S_RUN) && (conv_cnt == len_q - 1'b1);
  assign hold_end = (hold_cnt == hold_q - 1'b1);

  always_comb
    for (int i = 0; i < ORD_MAX; i++) msk[i] = (i < int'(ord_q));

  assign busy_o      = (st == S_RUN);
  assign clear_o     = (st == S_CLR);
  assign inv_o       = busy_o & (^(elem & msk));
  assign phase_sel_o = inv_o ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ord_q    <= OW'(1);
      hold_q   <= HOLD_W'(1);
      len_q    <= LEN_W'(1);
      hold_cnt <= '0;
      conv_cnt <= '0;
      elem     <= '0;
      pend     <= 1'b0;
    end else begin
      if (start_i) begin
        ord_q  <= ord_n;
        hold_q <= hold_n;
        len_q  <= len_n;
      end
      unique case (st)
        S_IDLE: if (start_i) begin
          st       <= S_RUN;
          hold_cnt <= '0;
          conv_cnt <= '0;
          elem     <= '0;
        end
        S_RUN: begin
          if (last) begin
            st   <= S_CLR;
            pend <= start_i;
          end else if (start_i) begin
            hold_cnt <= '0;
            conv_cnt <= '0;
            elem     <= '0;
          end else begin
            conv_cnt <= conv_cnt + 1'b1;
            if (hold_end) begin
              hold_cnt <= '0;
              elem     <= elem + 1'b1;
            end else begin
              hold_cnt <= hold_cnt + 1'b1;
            end
          end
        end
        S_CLR: begin
          pend <= 1'b0;
          if (pend || start_i) begin
            st       <= S_RUN;
            hold_cnt <= '0;
            conv_cnt <= '0;
            elem     <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_inv_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !inv_o);

  p_inv_stable_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hold_cnt != '0) |-> $stable(inv_o));

  p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> !clear_o);

  p_clear_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> $past(busy_o));

  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (conv_cnt < len_q));

  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(start_i)) |->
      ($stable(ord_q) && $stable(hold_q) && $stable(len_q)));

endmodule

// File: tb/test_fractal_inv_seq.sv
module test_fractal_inv_seq;
  logic clk = 0, rst_n = 0, start_i = 0;
  logic [2:0]  order_i = 3'd3;
  logic [7:0]  hold_i  = 8'd64;
  logic [11:0] len_i   = 12'd2048;
  logic inv_o, busy_o, clear_o;
  logic [1:0] phase_sel_o;
  int checks = 0, fails = 0;
  int seq [16];
  bit done = 0;

  fractal_inv_seq i_fractal_inv_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .order_i(order_i),
    .hold_i(hold_i), .len_i(len_i), .inv_o(inv_o),
    .phase_sel_o(phase_sel_o), .busy_o(busy_o), .clear_o(clear_o));

  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_inv(int p, int ord, int hold);
    return seq[(p / hold) % (1 << ord)];
  endfunction

  task automatic pulse_start(int ord, int hold, int len);
    @(negedge clk);
    order_i = 3'(ord); hold_i = 8'(hold); len_i = 12'(len); start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic run_periods(int p0, int n, int ord, int hold, output int errs);
    errs = 0;
    for (int p = p0; p < p0 + n; p++) begin
      if (busy_o !== 1'b1 || clear_o !== 1'b0 || inv_o !== 1'(exp_inv(p, ord, hold)) ||
          phase_sel_o !== (inv_o ? 2'b10 : 2'b01)) begin
        if (errs == 0)
          $display("  mismatch at period %0d: busy=%0b inv=%0b phase=%b exp_inv=%0d",
                   p, busy_o, inv_o, phase_sel_o, exp_inv(p, ord, hold));
        errs++;
      end
      if (p < p0 + n - 1) @(negedge clk);
    end
  endtask

  task automatic check_end(string tag);
    @(negedge clk);
    chk({tag, " clear_o high after last period"}, clear_o, 1);
    chk({tag, " busy_o low in clear cycle"}, busy_o, 0);
    @(negedge clk);
    chk({tag, " clear_o single cycle"}, clear_o, 0);
    chk({tag, " idle after clear"}, busy_o, 0);
    chk({tag, " R11 inv_o low when idle"}, inv_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 inv_o after reset", inv_o, 0);
    chk("R1 busy_o after reset", busy_o, 0);
    chk("R1 clear_o after reset", clear_o, 0);
    chk("R1 phase_sel_o after reset", phase_sel_o, 1);
  endtask

  task automatic t_default;
    int e;
    pulse_start(3, 64, 2048);
    chk("R2 busy_o in period 0", busy_o, 1);
    chk("R2 inv_o low in period 0", inv_o, 0);
    run_periods(0, 2048, 3, 64, e);
    chk("R3 R5 default pattern errors", e, 0);
    check_end("R6 default");
  endtask

  task automatic t_orders;
    int e;
    pulse_start(1, 3, 20);
    run_periods(0, 20, 1, 3, e);
    chk("R4 order 1 alternation errors", e, 0);
    check_end("R4 order 1");
    pulse_start(4, 2, 40);
    run_periods(0, 40, 4, 2, e);
    chk("R4 order 4 pattern errors", e, 0);
    check_end("R4 order 4");
  endtask

  task automatic t_cfg_ignored;
    int e;
    pulse_start(2, 4, 32);
    run_periods(0, 2, 2, 4, e);
    order_i = 3'd4; hold_i = 8'd1; len_i = 12'd5;
    @(negedge clk);
    begin
      int e2;
      run_periods(2, 30, 2, 4, e2);
      chk("R7 pattern unchanged by input changes", e + e2, 0);
    end
    check_end("R7 length unchanged");
  endtask

  task automatic t_restart;
    int e, clr;
    clr = 0;
    pulse_start(2, 2, 16);
    for (int p = 0; p < 5; p++) begin
      if (clear_o) clr++;
      @(negedge clk);
    end
    pulse_start(3, 1, 12);
    chk("R8 busy after restart", busy_o, 1);
    chk("R8 no clear on restart", clr + int'(clear_o), 0);
    run_periods(0, 12, 3, 1, e);
    chk("R8 pattern from period 0 after restart", e, 0);
    check_end("R8 end");
  endtask

  task automatic t_coincide;
    int e;
    pulse_start(3, 1, 8);
    run_periods(0, 8, 3, 1, e);
    order_i = 3'd2; hold_i = 8'd2; len_i = 12'd6; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R9 clear_o with start in last period", clear_o, 1);
    chk("R9 busy_o low in clear cycle", busy_o, 0);
    @(negedge clk);
    chk("R9 new conversion follows clear", busy_o, 1);
    chk("R9 inv_o low in new period 0", inv_o, 0);
    run_periods(0, 6, 2, 2, e);
    chk("R9 pattern after deferred start", e, 0);
    @(negedge clk);
    chk("R9 clear after second run", clear_o, 1);
    order_i = 3'd1; hold_i = 8'd1; len_i = 12'd3; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R9 start in clear cycle begins run", busy_o, 1);
    run_periods(0, 3, 1, 1, e);
    chk("R9 pattern after start in clear", e, 0);
    check_end("R9 end");
  endtask

  task automatic t_clamp;
    int e;
    pulse_start(0, 2, 8);
    run_periods(0, 8, 1, 2, e);
    chk("R10 order 0 acts as 1", e, 0);
    check_end("R10 order 0");
    pulse_start(7, 1, 20);
    run_periods(0, 20, 4, 1, e);
    chk("R10 order 7 acts as 4", e, 0);
    check_end("R10 order 7");
    pulse_start(1, 0, 4);
    run_periods(0, 4, 1, 1, e);
    chk("R10 hold 0 acts as 1", e, 0);
    check_end("R10 hold 0");
    pulse_start(3, 4, 0);
    chk("R10 len 0 gives one busy period", busy_o, 1);
    check_end("R10 len 0");
    repeat (5) @(negedge clk);
    chk("R11 inv_o low while idle", inv_o, 0);
  endtask

  initial begin
    seq[0] = 0;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < (1 << k); i++) seq[(1 << k) + i] = 1 - seq[i];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default();
    t_orders();
    t_cfg_ignored();
    t_restart();
    t_coincide();
    t_clamp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule